// File: doc/BRIEF.md
# Event and FIFO Timing Monitor

This block sits beside an input FIFO inside a processing engine and measures performance in clock cycles. The first measurement is per-event processing time. The event counter starts when the first word of an event is popped from the FIFO. It stops when the end-of-event word of that event is popped. The elapsed count is then latched into a register the host can read.

Two more counters add up, across many events, how many cycles the FIFO spends empty and how many cycles its half-full (hold) flag is raised. All three values are 32 bits wide by default. Every counter saturates at its maximum value instead of wrapping. A host write pulse clears the two running totals and leaves the last event time alone. The asynchronous reset clears everything.

Top module: `event_fifo_timer`

## Requirements
- R1: After reset, `lastEventTime`, `emptyCycles` and `holdCycles` all read 0.
- R2: A pop with `popFirst=1` opens an event. A later pop with `popLast=1` closes it. After the closing edge, `lastEventTime` equals the number of clock edges from the opening pop to the closing pop. Marker-free pops in between have no effect.
- R3: A single pop that has both `popFirst=1` and `popLast=1` records an event time of 0.
- R4: A pop with `popLast=1` while no event is open leaves `lastEventTime` unchanged. Marker inputs that are raised while `popValid=0` are ignored.
- R5: A first-word pop while an event is already open restarts the measurement from that pop.
- R6: `emptyCycles` increases by one on every clock edge at which `fifoEmpty=1`, and holds its value otherwise.
- R7: `holdCycles` increases by one on every clock edge at which `fifoHalfFull=1`, and holds its value otherwise.
- R8: A `clearTotals` pulse sets `emptyCycles` and `holdCycles` to 0 on that edge. The clear takes priority over a raised flag, and it does not change `lastEventTime`.
- R9: Every counter stops at its all-ones value and does not wrap. An event longer than that maximum records the maximum.
- R10: The counter width is set by parameter `CNT_W`, which defaults to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| popValid | input | 1 | A word is popped from the FIFO this cycle |
| popFirst | input | 1 | The popped word is the first of an event |
| popLast | input | 1 | The popped word is the end-of-event word |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoHalfFull | input | 1 | FIFO half-full (hold) flag |
| clearTotals | input | 1 | Host write pulse that clears both flag totals |
| lastEventTime | output | CNT_W | Duration of the most recently closed event |
| emptyCycles | output | CNT_W | Total cycles the FIFO has been empty |
| holdCycles | output | CNT_W | Total cycles the hold flag has been raised |

## Verification
The bench covers several corner cases, each paired with the symptom a faulty design would show:
- A one-word event must record 0. A design that counts the closing pop as an extra tick records 1.
- A stray end-of-event pop must leave the stored time alone. A design that latches it overwrites the stored time with garbage.
- A second first-word pop must restart the count. A design that misses this reports the longer, stale span.
- Clearing the totals while both flags are high must give 0. If the increment wins over the clear, the total reads 1.
- A narrow-width instance drives every counter past its maximum. A wrapping design reads small values there instead of all ones.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

  // Strobes from the control to the datapath, one set per cycle
  typedef struct packed {
    logic evStart;   // open (or reopen) an event measurement
    logic evStop;    // close the open event and latch its time
    logic evRun;     // an event is open this cycle
    logic clrTotals; // clear both flag accumulators
    logic emptyTick; // FIFO empty this cycle
    logic holdTick;  // hold flag raised this cycle
  } ctlStrobes_t;

endpackage

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
  import perf_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        popValid,
  input  logic        popFirst,
  input  logic        popLast,
  input  logic        fifoEmpty,
  input  logic        fifoHalfFull,
  input  logic        clearTotals,
  output ctlStrobes_t ctl
);

  logic evOpen;
  logic firstPop;
  logic lastPop;

  assign firstPop = popValid & popFirst;
  // A closing pop counts only for an open event or one opened by the same pop
  assign lastPop  = popValid & popLast & (evOpen | popFirst);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evOpen <= 1'b0;
    end else if (lastPop) begin
      evOpen <= 1'b0;
    end else if (firstPop) begin
      evOpen <= 1'b1;
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.evStart   = firstPop;
    ctl.evStop    = lastPop;
    ctl.evRun     = evOpen;
    ctl.clrTotals = clearTotals;
    ctl.emptyTick = fifoEmpty;
    ctl.holdTick  = fifoHalfFull;
  end

endmodule

// File: rtl/perf_mon_datapath.sv
module perf_mon_datapath
  import perf_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  output logic [CNT_W-1:0] lastEventTime,
  output logic [CNT_W-1:0] emptyCycles,
  output logic [CNT_W-1:0] holdCycles
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int NUM_ACC = 2;

  logic [CNT_W-1:0] evCount;
  logic [CNT_W-1:0] evNext;

  assign evNext = (evCount == CNT_MAX) ? CNT_MAX : evCount + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evCount       <= '0;
      lastEventTime <= '0;
    end else begin
      if (ctl.evStop) begin
        lastEventTime <= ctl.evStart ? '0 : evNext;
      end
      if (ctl.evStart || ctl.evStop) begin
        evCount <= '0;
      end else if (ctl.evRun) begin
        evCount <= evNext;
      end
    end
  end

  logic [NUM_ACC-1:0] accTick;
  logic [CNT_W-1:0]   accVal [NUM_ACC];

  assign accTick = {ctl.holdTick, ctl.emptyTick};

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accVal[g] <= '0;
      end else if (ctl.clrTotals) begin
        accVal[g] <= '0;
      end else if (accTick[g] && accVal[g] != CNT_MAX) begin
        accVal[g] <= accVal[g] + 1'b1;
      end
    end
  end

  assign emptyCycles = accVal[0];
  assign holdCycles  = accVal[1];

endmodule

// File: rtl/event_fifo_timer.sv
module event_fifo_timer
  import perf_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             popValid,
  input  logic             popFirst,
  input  logic             popLast,
  input  logic             fifoEmpty,
  input  logic             fifoHalfFull,
  input  logic             clearTotals,
  output logic [CNT_W-1:0] lastEventTime,
  output logic [CNT_W-1:0] emptyCycles,
  output logic [CNT_W-1:0] holdCycles
);

  ctlStrobes_t ctl;

  perf_mon_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .popValid     (popValid),
    .popFirst     (popFirst),
    .popLast      (popLast),
    .fifoEmpty    (fifoEmpty),
    .fifoHalfFull (fifoHalfFull),
    .clearTotals  (clearTotals),
    .ctl          (ctl)
  );

  perf_mon_datapath #(.CNT_W(CNT_W)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .lastEventTime (lastEventTime),
    .emptyCycles   (emptyCycles),
    .holdCycles    (holdCycles)
  );

endmodule

// File: rtl/event_fifo_timer_chk.sv
module event_fifo_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             popValid,
  input logic             popFirst,
  input logic             popLast,
  input logic             fifoEmpty,
  input logic             fifoHalfFull,
  input logic             clearTotals,
  input logic [CNT_W-1:0] lastEventTime,
  input logic [CNT_W-1:0] emptyCycles,
  input logic [CNT_W-1:0] holdCycles
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(popValid && popLast) |=> $stable(lastEventTime));

  // R3
  single_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && popFirst && popLast) |=> lastEventTime == '0);

  // R6
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEmpty && !clearTotals) |=> $stable(emptyCycles));

  // R6
  empty_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !clearTotals && emptyCycles != CNT_MAX)
      |=> emptyCycles == $past(emptyCycles) + 1'b1);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoHalfFull && !clearTotals) |=> $stable(holdCycles));

  // R8
  clear_totals_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearTotals |=> (emptyCycles == '0 && holdCycles == '0));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdCycles == CNT_MAX && !clearTotals) |=> holdCycles == CNT_MAX);

endmodule

bind event_fifo_timer event_fifo_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .popValid      (popValid),
  .popFirst      (popFirst),
  .popLast       (popLast),
  .fifoEmpty     (fifoEmpty),
  .fifoHalfFull  (fifoHalfFull),
  .clearTotals   (clearTotals),
  .lastEventTime (lastEventTime),
  .emptyCycles   (emptyCycles),
  .holdCycles    (holdCycles)
);

// File: tb/event_fifo_timer_test.sv
module event_fifo_timer_test;

  localparam int NARROW_W = 4;
  localparam int NUM_VEC  = 6;
  // Each row: gap in edges between first and last pop, middle pops on (1) / off (0), expected time
  localparam int VEC [NUM_VEC][3] = '{
    '{1, 0, 1}, '{2, 1, 2}, '{5, 0, 5}, '{9, 1, 9}, '{3, 1, 3}, '{17, 0, 17}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic popValid = 1'b0, popFirst = 1'b0, popLast = 1'b0;
  logic fifoEmpty = 1'b0, fifoHalfFull = 1'b0, clearTotals = 1'b0;
  logic [31:0] lastEventTime, emptyCycles, holdCycles;
  logic [NARROW_W-1:0] nEvt, nEmpty, nHold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  event_fifo_timer uut (
    .clk(clk), .rstN(rstN), .popValid(popValid), .popFirst(popFirst),
    .popLast(popLast), .fifoEmpty(fifoEmpty), .fifoHalfFull(fifoHalfFull),
    .clearTotals(clearTotals), .lastEventTime(lastEventTime),
    .emptyCycles(emptyCycles), .holdCycles(holdCycles)
  );

  event_fifo_timer #(.CNT_W(NARROW_W)) uutNarrow (
    .clk(clk), .rstN(rstN), .popValid(popValid), .popFirst(popFirst),
    .popLast(popLast), .fifoEmpty(fifoEmpty), .fifoHalfFull(fifoHalfFull),
    .clearTotals(clearTotals), .lastEventTime(nEvt),
    .emptyCycles(nEmpty), .holdCycles(nHold)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs; returns at the next falling edge
  task automatic cyc(input logic v, input logic f, input logic l);
    popValid = v; popFirst = f; popLast = l;
    @(negedge clk);
    popValid = 1'b0; popFirst = 1'b0; popLast = 1'b0;
  endtask

  task automatic clearPulse();
    clearTotals = 1'b1;
    @(negedge clk);
    clearTotals = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lastEventTime", lastEventTime, 0);
    check("R1 emptyCycles", emptyCycles, 0);
    check("R1 holdCycles", holdCycles, 0);
    check("R10 width", 32'($bits(lastEventTime)), 32);
    rstN = 1'b1;
    @(negedge clk);

    // R2 table of event spans
    for (int i = 0; i < NUM_VEC; i++) begin
      cyc(1'b1, 1'b1, 1'b0);
      for (int k = 1; k < VEC[i][0]; k++) cyc(VEC[i][1] != 0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b1);
      check($sformatf("R2 event gap %0d", VEC[i][0]), lastEventTime, VEC[i][2]);
    end

    // R4 stray end-of-event pop with no event open
    cyc(1'b1, 1'b0, 1'b1);
    check("R4 stray last pop", lastEventTime, 17);
    // R4 markers without popValid are ignored
    cyc(1'b0, 1'b1, 1'b0);
    repeat (2) cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    check("R4 markers without pop", lastEventTime, 17);

    // R3 single-word event
    cyc(1'b1, 1'b1, 1'b1);
    check("R3 single word", lastEventTime, 0);

    // R5 restart on second first-word pop
    cyc(1'b1, 1'b1, 1'b0);
    repeat (5) cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    repeat (3) cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    check("R5 restart", lastEventTime, 4);

    // R6 empty time accumulation
    clearPulse();
    fifoEmpty = 1'b1;
    repeat (7) @(negedge clk);
    fifoEmpty = 1'b0;
    check("R6 empty count", emptyCycles, 7);
    repeat (4) @(negedge clk);
    check("R6 empty held", emptyCycles, 7);
    fifoEmpty = 1'b1;
    repeat (3) @(negedge clk);
    fifoEmpty = 1'b0;
    check("R6 empty resumes", emptyCycles, 10);

    // R7 hold time accumulation
    fifoHalfFull = 1'b1;
    repeat (11) @(negedge clk);
    fifoHalfFull = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 hold count", holdCycles, 11);

    // R8 clear wins over raised flags, event time untouched
    fifoEmpty = 1'b1; fifoHalfFull = 1'b1;
    clearPulse();
    check("R8 empty cleared", emptyCycles, 0);
    check("R8 hold cleared", holdCycles, 0);
    check("R8 event kept", lastEventTime, 4);
    @(negedge clk);
    fifoEmpty = 1'b0; fifoHalfFull = 1'b0;
    check("R8 counts after clear", emptyCycles + holdCycles, 2);

    // R9 saturation on the narrow instance (max 15)
    clearPulse();
    fifoEmpty = 1'b1; fifoHalfFull = 1'b1;
    repeat (20) @(negedge clk);
    fifoEmpty = 1'b0; fifoHalfFull = 1'b0;
    check("R9 empty saturates", 32'(nEmpty), 15);
    check("R9 hold saturates", 32'(nHold), 15);
    cyc(1'b1, 1'b1, 1'b0);
    repeat (24) cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    check("R9 event saturates", 32'(nEvt), 15);
    check("R9 wide event", lastEventTime, 25);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule